// File: doc/BRIEF.md
# Round-Robin SPI ADC Scanner

This block is a receive-only serial master that polls a set of external serial converters, one after another, with no software involvement. It produces a serial clock and a group of chip-select outputs, and it reads every converter through a single shared data input. Only one converter is selected at a time. The bits that arrive while a channel is selected therefore belong to that channel alone.

A mode input picks one of three frame formats. The 12-bit format serves one quad converter with four channels; two select lines drive its channel-select pins directly. The 15-bit and 16-bit formats serve up to eight single-channel converters; the select lines carry a 3-bit binary channel code for an external 3-to-8 decoder.

After each frame the selection is released for a programmable idle time, and then the next channel is taken. Every finished sample lands in a per-channel result register. A host reads these registers through a simple read port, and each register carries a valid flag that the read clears.

Top module: `rr_adc_scanner`

## Requirements
- R1: After reset, `csOut[3]` is high, `sclk` is low, and a read of any of the eight channels returns 17'h0 (valid flag clear, data zero).
- R2: During a frame, `csOut[3]` is low and `csOut[2:0]` holds the binary channel code, which stays stable for the whole frame. `csOut[7:4]` are always high. Channels follow 0,1,2,… and wrap to 0 after the last channel. Every enable from the stopped state begins at channel 0.
- R3: `cfgMode` 0 selects 12-bit frames over channels 0 to 3, with `csOut[2]` held at 0. `cfgMode` 1 selects 15-bit frames over channels 0 to 7. `cfgMode` 2, and the code 3, select 16-bit frames over channels 0 to 7.
- R4: Each frame has exactly as many rising `sclk` edges as the format has bits. `miso` is sampled at each rising edge, MSB first. The stored result is right-justified in 16 bits, with the unused upper bits zero.
- R5: `sclk` is low whenever `csOut[3]` is high. While a frame runs, each `sclk` level lasts max(`cfgHalfDiv`,1) clock cycles. The first rising edge comes that many cycles after `csOut[3]` falls.
- R6: Between two frames of a running scan, `csOut[3]` stays high for exactly max(`cfgIdle`,1) clock cycles.
- R7: A read with `rdEn` high and channel `rdAddr` presents `{valid, data}` on `rdData` (bit 16 is the valid flag, bits 15:0 are the data) on the next clock cycle. `rdData` holds its value between reads.
- R8: A channel's valid flag is set in the cycle its result is stored and cleared by a read of that channel. If a store and a read of the same channel fall in the same cycle, the flag stays set.
- R9: When `cfgEnable` is cleared during a frame, that frame completes and its result is stored. After that, no further frame starts until `cfgEnable` is set again.
- R10: `cfgMode` is taken only when a scan starts from the stopped state. A change of `cfgMode` while the scan runs has no effect on frame width or channel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Scan enable; clearing it stops the scan at the next frame end |
| cfgMode | input | 2 | Frame format select (0: 12-bit/4 ch, 1: 15-bit/8 ch, 2 or 3: 16-bit/8 ch) |
| cfgHalfDiv | input | DIV_W | Serial clock half period in clock cycles (0 acts as 1) |
| cfgIdle | input | IDLE_W | Deselect time between frames in clock cycles (0 acts as 1) |
| miso | input | 1 | Shared serial data input from all converters |
| sclk | output | 1 | Serial clock |
| csOut | output | 8 | [2:0] channel code, [3] active-low frame select, [7:4] held high |
| rdEn | input | 1 | Read strobe for the result bank |
| rdAddr | input | 3 | Channel to read |
| rdData | output | 17 | Read result: [16] valid flag, [15:0] sample |

## Verification
The falling edge of `csOut[3]` is the point from which all frame timing is measured. The first `sclk` rise follows it by one half period, and later edges come one half period apart. The result is written on the same clock edge that raises `csOut[3]`, and a read returns it one edge after `rdEn`. The bench samples every output at the falling clock edge. At each such point it counts half periods, gap cycles and rising edges and compares them with values it computes from its own copy of the configuration. It issues a read only after it has seen a frame end, and it compares the read data on the falling edge that follows the registering edge.

// File: rtl/rr_adc_pkg.sv
package rr_adc_pkg;
  localparam int CH_NUM = 8;
  localparam int CH_W   = $clog2(CH_NUM);
  localparam int DATA_W = 16;
  localparam int RD_W   = DATA_W + 1;
  localparam int BIT_W  = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    FMT_A = 2'd0,   // 12-bit, quad converter, 4 channels
    FMT_B = 2'd1,   // 15-bit, 8 channels, decoded select
    FMT_C = 2'd2    // 16-bit, 8 channels, decoded select
  } fmt_e;

  // control -> datapath strobes
  typedef struct packed {
    logic            frameStart;
    logic            shiftEn;
    logic            store;
    logic [CH_W-1:0] chan;
  } strobes_t;

  function automatic fmt_e decodeMode(input logic [1:0] code);
    case (code)
      2'd0:    return FMT_A;
      2'd1:    return FMT_B;
      default: return FMT_C;
    endcase
  endfunction

  function automatic logic [BIT_W-1:0] frameBits(input fmt_e f);
    case (f)
      FMT_A:   return BIT_W'(12);
      FMT_B:   return BIT_W'(15);
      default: return BIT_W'(16);
    endcase
  endfunction

  function automatic logic [CH_W-1:0] lastChan(input fmt_e f);
    return (f == FMT_A) ? CH_W'(3) : CH_W'(CH_NUM - 1);
  endfunction
endpackage

// File: rtl/rr_adc_ctrl.sv
module rr_adc_ctrl
  import rr_adc_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        modeSel,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic [IDLE_W-1:0] idleLen,
  output strobes_t          strobes,
  output logic              sclk,
  output logic              selN,
  output logic [CH_W-1:0]   chanCode,
  output fmt_e              fmtQ,
  output logic              running
);
  typedef enum logic [1:0] {ST_STOP, ST_SHIFT, ST_GAP} st_e;

  st_e               state;
  logic [DIV_W-1:0]  divCnt;
  logic [IDLE_W-1:0] gapCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [CH_W-1:0]   chanQ;
  logic              sclkQ;

  logic [DIV_W-1:0]  halfLim;
  logic [IDLE_W-1:0] gapLim;
  logic              tick;
  logic              gapDone;
  logic              lastBit;
  logic [CH_W-1:0]   nextChan;

  always_comb begin
    halfLim  = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
    gapLim   = (idleLen == '0) ? IDLE_W'(1) : idleLen;
    tick     = (divCnt == halfLim - DIV_W'(1));
    gapDone  = (gapCnt == gapLim - IDLE_W'(1));
    lastBit  = (bitCnt == frameBits(fmtQ) - BIT_W'(1));
    nextChan = (chanQ == lastChan(fmtQ)) ? '0 : chanQ + CH_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_STOP;
      divCnt <= '0;
      gapCnt <= '0;
      bitCnt <= '0;
      chanQ  <= '0;
      sclkQ  <= 1'b0;
      fmtQ   <= FMT_A;
    end else begin
      case (state)
        ST_STOP: begin
          sclkQ <= 1'b0;
          if (enable) begin
            fmtQ   <= decodeMode(modeSel);
            chanQ  <= '0;
            divCnt <= '0;
            bitCnt <= '0;
            state  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            sclkQ  <= ~sclkQ;
            if (sclkQ) begin
              if (lastBit) begin
                state  <= ST_GAP;
                gapCnt <= '0;
              end else begin
                bitCnt <= bitCnt + BIT_W'(1);
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (gapDone) begin
            if (enable) begin
              chanQ  <= nextChan;
              divCnt <= '0;
              bitCnt <= '0;
              state  <= ST_SHIFT;
            end else begin
              state <= ST_STOP;
            end
          end else begin
            gapCnt <= gapCnt + IDLE_W'(1);
          end
        end
        default: state <= ST_STOP;
      endcase
    end
  end

  always_comb begin
    strobes.frameStart = ((state == ST_STOP) && enable) ||
                         ((state == ST_GAP) && gapDone && enable);
    strobes.shiftEn    = (state == ST_SHIFT) && tick && !sclkQ;
    strobes.store      = (state == ST_SHIFT) && tick && sclkQ && lastBit;
    strobes.chan       = chanQ;
  end

  assign sclk     = sclkQ;
  assign selN     = (state != ST_SHIFT);
  assign chanCode = chanQ;
  assign running  = (state != ST_STOP);
endmodule

// File: rtl/rr_adc_dp.sv
module rr_adc_dp
  import rr_adc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              miso,
  input  strobes_t          strobes,
  input  logic              rdEn,
  input  logic [CH_W-1:0]   rdAddr,
  output logic [RD_W-1:0]   rdData,
  output logic [CH_NUM-1:0] validVec
);
  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] bankQ [CH_NUM];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strobes.frameStart) begin
      shiftQ <= '0;
    end else if (strobes.shiftEn) begin
      shiftQ <= {shiftQ[DATA_W-2:0], miso};
    end
  end

  for (genvar g = 0; g < CH_NUM; g++) begin : gBank
    logic hit;
    logic rdHit;
    assign hit   = strobes.store && (strobes.chan == CH_W'(g));
    assign rdHit = rdEn && (rdAddr == CH_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ[g]    <= '0;
        validVec[g] <= 1'b0;
      end else if (hit) begin
        bankQ[g]    <= shiftQ;
        validVec[g] <= 1'b1;
      end else if (rdHit) begin
        validVec[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= {validVec[rdAddr], bankQ[rdAddr]};
    end
  end
endmodule

// File: rtl/rr_adc_scanner.sv
module rr_adc_scanner
  import rr_adc_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgMode,
  input  logic [DIV_W-1:0]  cfgHalfDiv,
  input  logic [IDLE_W-1:0] cfgIdle,
  input  logic              miso,
  output logic              sclk,
  output logic [7:0]        csOut,
  input  logic              rdEn,
  input  logic [2:0]        rdAddr,
  output logic [16:0]       rdData
);
  localparam int SPARE_W = 8 - CH_W - 1;

  strobes_t          strobes;
  fmt_e              fmtQ;
  logic              running;
  logic              selN;
  logic [CH_W-1:0]   chanCode;
  logic [CH_NUM-1:0] validVec;

  rr_adc_ctrl #(.DIV_W(DIV_W), .IDLE_W(IDLE_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (cfgEnable),
    .modeSel  (cfgMode),
    .halfDiv  (cfgHalfDiv),
    .idleLen  (cfgIdle),
    .strobes  (strobes),
    .sclk     (sclk),
    .selN     (selN),
    .chanCode (chanCode),
    .fmtQ     (fmtQ),
    .running  (running)
  );

  rr_adc_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .miso     (miso),
    .strobes  (strobes),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .validVec (validVec)
  );

  assign csOut = {{SPARE_W{1'b1}}, selN, chanCode};
endmodule

// File: rtl/rr_adc_scanner_chk.sv
module rr_adc_scanner_chk
  import rr_adc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sclk,
  input logic [7:0]        csOut,
  input logic              rdEn,
  input logic [2:0]        rdAddr,
  input strobes_t          strobes,
  input fmt_e              fmtQ,
  input logic [CH_NUM-1:0] validVec
);
  // R5: serial clock parked low while deselected
  assert_sclk_parked_R5: assert property (@(posedge clk) disable iff (!rstN)
    csOut[3] |-> !sclk);

  // R2: channel code does not move inside a frame
  assert_code_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!csOut[3] && $past(!csOut[3])) |-> $stable(csOut[2:0]));

  // R3: quad-converter format never drives select bit 2
  assert_quad_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fmtQ == FMT_A) |-> !csOut[2]);

  // R8: a stored result raises its valid flag
  assert_store_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.store |=> validVec[$past(strobes.chan)]);

  // R8: a read without a colliding store clears the flag
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdEn) && !($past(strobes.store) && ($past(strobes.chan) == $past(rdAddr))))
      |-> !validVec[$past(rdAddr)]);
endmodule

bind rr_adc_scanner rr_adc_scanner_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .sclk     (sclk),
  .csOut    (csOut),
  .rdEn     (rdEn),
  .rdAddr   (rdAddr),
  .strobes  (strobes),
  .fmtQ     (fmtQ),
  .validVec (validVec)
);

// File: tb/sim_rr_adc_scanner.sv
module sim_rr_adc_scanner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic [7:0]  cfgHalfDiv = 8'd1;
  logic [7:0]  cfgIdle = 8'd2;
  logic        miso = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdAddr = 3'd0;
  wire         sclk;
  wire  [7:0]  csOut;
  wire  [16:0] rdData;

  rr_adc_scanner u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
    .cfgHalfDiv(cfgHalfDiv), .cfgIdle(cfgIdle), .miso(miso), .sclk(sclk),
    .csOut(csOut), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int widthOf(input int m);
    return (m == 0) ? 12 : (m == 1) ? 15 : 16;
  endfunction
  function automatic int lastOf(input int m);
    return (m == 0) ? 3 : 7;
  endfunction
  function automatic int atLeastOne(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction
  function automatic logic [15:0] maskOf(input int m);
    return 16'((32'd1 << widthOf(m)) - 1);
  endfunction

  // converter model and frame monitor state
  int          runMode = 0;
  logic [15:0] expVal [8];
  logic [15:0] curVal = '0;
  int k = 0, halfCnt = 0, gapCnt = 0, rises = 0;
  int doneCnt = 0, doneChan = 0, expChan = 0, curChan = 0;
  bit firstFrame = 1'b1, prevSel = 1'b1, prevSclk = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevSel && !csOut[3]) begin
        chk(csOut[2:0] == 3'(expChan), "R2 channel order", csOut[2:0], expChan);
        chk(csOut[7:4] == 4'hF, "R2 spare selects high", csOut[7:4], 4'hF);
        if (!firstFrame)
          chk(gapCnt == atLeastOne(cfgIdle), "R6 idle gap", gapCnt, atLeastOne(cfgIdle));
        firstFrame = 1'b0;
        curChan = int'(csOut[2:0]);
        curVal = 16'($urandom) & maskOf(runMode);
        expVal[curChan] = curVal;
        k = 0;
        miso = curVal[widthOf(runMode)-1];
        halfCnt = 0;
        rises = 0;
      end else if (!csOut[3]) begin
        halfCnt++;
        if (sclk != prevSclk) begin
          chk(halfCnt == atLeastOne(cfgHalfDiv), "R5 half period", halfCnt, atLeastOne(cfgHalfDiv));
          halfCnt = 0;
          if (sclk) rises++;
          else begin
            k++;
            if (k < widthOf(runMode)) miso = curVal[widthOf(runMode)-1-k];
          end
        end
      end else if (!prevSel && csOut[3]) begin
        chk(rises == widthOf(runMode), "R4 rising edges per frame", rises, widthOf(runMode));
        doneChan = curChan;
        doneCnt++;
        expChan = (curChan == lastOf(runMode)) ? 0 : curChan + 1;
        gapCnt = 1;
      end else begin
        gapCnt++;
      end
      prevSel = csOut[3];
      prevSclk = sclk;
    end
  end

  task automatic readCh(input int c, output logic [16:0] val);
    @(negedge clk);
    rdEn = 1'b1;
    rdAddr = 3'(c);
    @(negedge clk);
    rdEn = 1'b0;
    val = rdData;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [16:0] got;
    int seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(csOut[3] == 1'b1, "R1 select idle in reset", csOut[3], 1);
    chk(sclk == 1'b0, "R1 sclk low in reset", sclk, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      readCh(c, got);
      chk(got == 17'h0, "R1 bank cleared", got, 0);
    end

    for (int m = 0; m < 4; m++) begin
      runMode = (m == 3) ? 2 : m;
      cfgMode = 2'(m);
      cfgHalfDiv = (m == 1) ? 8'd0 : 8'(1 + $urandom % 4);
      cfgIdle    = (m == 2) ? 8'd0 : 8'(2 + $urandom % 6);
      expChan = 0;
      firstFrame = 1'b1;
      @(negedge clk);
      cfgEnable = 1'b1;
      for (int f = 0; f < lastOf(runMode) + 5; f++) begin
        int c;
        seen = doneCnt;
        wait (doneCnt != seen);
        c = doneChan;
        readCh(c, got);
        if (m == 1 && f > 3)
          chk(got == {1'b1, expVal[c]}, "R10 format kept after mode change", got, {1'b1, expVal[c]});
        else
          chk(got == {1'b1, expVal[c]}, "R4/R7 sample read", got, {1'b1, expVal[c]});
        readCh(c, got);
        chk(got == {1'b0, expVal[c]}, "R8 valid cleared by read", got, {1'b0, expVal[c]});
        if (m == 1 && f == 3) cfgMode = 2'd0;   // must be ignored while running
      end
      // stop in the middle of a frame
      @(negedge clk);
      while (csOut[3]) @(negedge clk);
      cfgEnable = 1'b0;
      seen = doneCnt;
      wait (doneCnt != seen);
      readCh(doneChan, got);
      chk(got == {1'b1, expVal[doneChan]}, "R9 last frame stored", got, {1'b1, expVal[doneChan]});
      repeat (100) @(negedge clk);
      chk(doneCnt == seen + 1, "R9 no frame after stop", doneCnt, seen + 1);
      chk(csOut[3] == 1'b1, "R9 select released", csOut[3], 1);
    end
    summary();
  end
endmodule